// File: doc/BRIEF.md
# I2C Word Target with CRC-8 Packet Checking

This block is an I2C target that gives a host controller word-wide access to a register file. The host selects a register with a command byte. It then writes a 16-bit value, low byte first, or it reads one back after a repeated START. Every transfer carries a trailing CRC-8 byte that covers the whole packet, address bytes included. On a write the CRC guards the data: the register file is only updated when the CRC byte received matches the CRC computed by the target. On a read the target appends its own CRC, so the host can validate the word it received.

SCL and SDA are oversampled in the system clock domain through two-flop synchronizers, so the system clock must run at least 20 times faster than the bus clock. The target drives the bus only through two pull-down enables, one for SDA and one for SCL. The SDA pull-down carries acknowledge bits and read data. The SCL pull-down holds the clock low for the brief register fetch at the start of a read. A timer is restarted at every ninth SCL rising edge and at every START. If a transfer stalls long enough for the timer to reach its limit, the target lets go of the bus and ignores all traffic until the next START.

Top module: `i2c_crc_word_target`

## Requirements
- R1: The target acknowledges a first byte of 0x16 (address 0x0B with write) or 0x17 (address 0x0B with read). Any other first byte is not acknowledged, and the target then leaves SDA released for every byte until the next START.
- R2: A write transfer is START, 0x16, command, low byte, high byte, CRC, STOP. The target acknowledges all five bytes. It raises `reg_we_o` for exactly one cycle with `reg_addr_o` equal to the command and `reg_wdata_o` equal to {high, low}. This happens in a cycle in which it is also driving the acknowledge for the CRC byte.
- R3: The CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, bits taken MSB first, and no final XOR. It runs from the 0x16 address byte through the last data byte. For example, 0x16,0x09,0x55,0xAA gives 0x3B.
- R4: If a write carries a wrong CRC byte, or ends with STOP before any CRC byte, `reg_we_o` never rises and the register keeps its value. A wrong CRC byte is still acknowledged.
- R5: A read transfer is START, 0x16, command, repeated START, 0x17. The target then sends the low byte, the high byte and a CRC over 0x16, command, 0x17, low and high. For example, a register holding 0x0EC2 read with command 0x09 gives the CRC 0x86. The host acknowledges the two data bytes and NACKs the CRC byte.
- R6: Each read raises `reg_rd_o` exactly once, for one cycle, and captures `reg_rdata_i` in the following cycle. `scl_pull_o` is high in exactly those two cycles and at no other time.
- R7: Command bytes 0x00, 0x01 and every value from 0x40 upward are not acknowledged. The rest of that transfer is ignored, and no write takes place.
- R8: If `TIMEOUT_CYC` system clocks pass during a transfer without a ninth SCL rising edge or a START, the target releases SDA and SCL and ignores all bytes until the next START. A write cut off in this way has no effect.
- R9: The timer restarts at each ninth SCL rising edge. A transfer whose gaps are each shorter than the limit completes normally, even when the gaps add up to more than the limit.
- R10: After reset, both pull-down enables and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| reg_addr_o | output | 8 | Register index taken from the command byte |
| reg_wdata_o | output | 16 | Word to be written |
| reg_we_o | output | 1 | One-cycle write strobe, issued only after a valid CRC |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 16 | Register word, sampled the cycle after `reg_rd_o` |

## Verification
Two functions share one cycle in this block. The write commit strobe fires in the same cycle that the target starts driving the acknowledge for the CRC byte. The read strobe fires in the same cycle that clock stretching begins. Every good write provokes the first pair. It is judged on the bus by the acknowledge the bench controller samples, and at the register file by exactly one strobe and the new content. Writes with a corrupted CRC produce the acknowledge without the commit, which separates the two functions. Every read provokes the second pair, which is judged by counting strobe cycles and stretch cycles and by the returned data and CRC. The timer restart and the timer limit are placed against each other by stalling SCL low once for longer than the limit, and by stalling several times, each time for less than the limit.

// File: rtl/i2c_crc_word_target.sv
module i2c_crc_word_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h0B,
  parameter int         TIMEOUT_CYC = 1_300_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_pull_o,
  output logic        sda_pull_o,
  output logic [7:0]  reg_addr_o,
  output logic [15:0] reg_wdata_o,
  output logic        reg_we_o,
  output logic        reg_rd_o,
  input  logic [15:0] reg_rdata_i
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_WLO, S_WHI, S_WCRC, S_RLO, S_RHI, S_RCRC, S_LAST
  } st_t;

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[6:0], 1'b0} ^ ((r[7] ^ d[i]) ? 8'h07 : 8'h00);
    return r;
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire bus_start = scl_s & scl_q & sda_q & ~sda_s;
  wire bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  st_t         st;
  logic [3:0]  bitcnt;
  logic [7:0]  rx, txsh, cmd, crc;
  logic [15:0] wword, rword;
  logic        ack_drv, tx_drv, txbyte, stretch, we, rd;
  logic [TW-1:0] tmo;

  wire ninth     = scl_rise && (bitcnt == 4'd8);
  wire tmo_abort = (st != S_IDLE) && (tmo == TW'(TIMEOUT_CYC - 1)) && !ninth && !bus_start;
  wire cmd_ok    = (rx >= 8'h02) && (rx < 8'h40);

  assign sda_pull_o  = ack_drv | (tx_drv & ~txsh[7]);
  assign scl_pull_o  = stretch;
  assign reg_addr_o  = cmd;
  assign reg_wdata_o = wword;
  assign reg_we_o    = we;
  assign reg_rd_o    = rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 tmo <= '0;
    else if (st == S_IDLE || bus_start || ninth) tmo <= '0;
    else                                        tmo <= tmo + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; rx <= '0; txsh <= '0; cmd <= '0; crc <= '0;
      wword <= '0; rword <= '0; ack_drv <= 1'b0; tx_drv <= 1'b0; txbyte <= 1'b0;
      stretch <= 1'b0; we <= 1'b0; rd <= 1'b0;
    end else begin
      we <= 1'b0;
      rd <= 1'b0;
      if (rd) begin
        rword <= reg_rdata_i; txsh <= reg_rdata_i[7:0]; tx_drv <= 1'b1; txbyte <= 1'b1;
      end else begin
        stretch <= 1'b0;
      end
      if (bus_start) begin
        st <= S_ADDR; bitcnt <= '0;
        ack_drv <= 1'b0; tx_drv <= 1'b0; txbyte <= 1'b0; stretch <= 1'b0;
      end else if (bus_stop || tmo_abort) begin
        st <= S_IDLE;
        ack_drv <= 1'b0; tx_drv <= 1'b0; txbyte <= 1'b0; stretch <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
          if (bitcnt < 4'd8) rx <= {rx[6:0], sda_s};
          if (bitcnt == 4'd8 && txbyte && sda_s) st <= S_LAST;
        end
        if (scl_fall) begin
          if (tx_drv && bitcnt >= 4'd1 && bitcnt <= 4'd7) txsh <= {txsh[6:0], 1'b0};
          if (bitcnt == 4'd8) begin
            tx_drv <= 1'b0;
            case (st)
              S_ADDR:
                if (rx[7:1] == DEV_ADDR) begin
                  ack_drv <= 1'b1;
                  if (rx[0]) begin st <= S_RLO; crc <= crc_upd(crc, rx); end
                  else       begin st <= S_CMD; crc <= crc_upd(8'h00, rx); end
                end else st <= S_LAST;
              S_CMD:
                if (cmd_ok) begin
                  ack_drv <= 1'b1; cmd <= rx; crc <= crc_upd(crc, rx); st <= S_WLO;
                end else st <= S_LAST;
              S_WLO:  begin ack_drv <= 1'b1; wword[7:0]  <= rx; crc <= crc_upd(crc, rx); st <= S_WHI; end
              S_WHI:  begin ack_drv <= 1'b1; wword[15:8] <= rx; crc <= crc_upd(crc, rx); st <= S_WCRC; end
              S_WCRC: begin ack_drv <= 1'b1; we <= (rx == crc); st <= S_LAST; end
              S_RLO:  begin crc <= crc_upd(crc, rword[7:0]);  st <= S_RHI; end
              S_RHI:  begin crc <= crc_upd(crc, rword[15:8]); st <= S_RCRC; end
              default: st <= S_LAST;
            endcase
          end
          if (bitcnt == 4'd9) begin
            ack_drv <= 1'b0; txbyte <= 1'b0; bitcnt <= '0;
            case (st)
              S_RLO:  begin rd <= 1'b1; stretch <= 1'b1; end
              S_RHI:  begin txsh <= rword[15:8]; tx_drv <= 1'b1; txbyte <= 1'b1; end
              S_RCRC: begin txsh <= crc;         tx_drv <= 1'b1; txbyte <= 1'b1; end
              S_LAST: st <= S_IDLE;
              default: ;
            endcase
          end
        end
      end
    end
  end

endmodule

module i2c_crc_word_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_pull_o,
  input logic       sda_pull_o,
  input logic       reg_we_o,
  input logic       reg_rd_o,
  input logic [7:0] reg_addr_o
);
  // R2
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);
  // R2
  we_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> sda_pull_o);
  // R7
  we_cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (reg_addr_o >= 8'h02 && reg_addr_o < 8'h40));
  // R6
  rd_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |-> scl_pull_o);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> (scl_pull_o && !reg_rd_o));
  // R6
  stretch_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> reg_rd_o);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_rd_o));
endmodule

bind i2c_crc_word_target i2c_crc_word_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
  .reg_we_o(reg_we_o), .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_crc_word_target_tb_top.sv
module i2c_crc_word_target_tb_top;
  localparam int H   = 12;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic scl_pull, sda_pull, reg_we, reg_rd;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  wire scl_line = scl_drv & ~scl_pull;
  wire sda_line = sda_drv & ~sda_pull;

  logic [15:0] rf [0:63];
  assign reg_rdata = rf[reg_addr[5:0]];

  int vec = 0, miss = 0, we_cnt = 0, rd_cnt = 0, str_cnt = 0;
  logic done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) rf[i] <= 16'(i * 16'h0101) ^ 16'h5A5A;
    end else begin
      if (reg_we) begin rf[reg_addr[5:0]] <= reg_wdata; we_cnt++; end
      if (reg_rd) rd_cnt++;
      if (scl_pull) str_cnt++;
    end
  end

  i2c_crc_word_target #(.DEV_ADDR(7'h0B), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic scl_up(); scl_drv = 1'b1; do @(negedge clk); while (!scl_line); endtask
  task automatic put_bit(input logic b);
    tick(2); sda_drv = b; tick(H - 2); scl_up(); tick(H); scl_drv = 1'b0;
  endtask
  task automatic get_bit(output logic b);
    tick(2); sda_drv = 1'b1; tick(H - 2); scl_up(); tick(H / 2); b = sda_line; tick(H - H / 2); scl_drv = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b); ack = !b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(nack);
  endtask
  task automatic bus_start();
    tick(2); sda_drv = 1'b1; tick(H); scl_up(); tick(H); sda_drv = 1'b0; tick(H); scl_drv = 1'b0;
  endtask
  task automatic bus_stop();
    tick(2); sda_drv = 1'b0; tick(H); scl_up(); tick(H); sda_drv = 1'b1; tick(H);
  endtask

  function automatic logic [7:0] wr_crc(input logic [7:0] cmd, input logic [15:0] d);
    return ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h16), cmd), d[7:0]), d[15:8]);
  endfunction

  task automatic wr(input logic [7:0] adr, input logic [7:0] cmd, input logic [15:0] d,
                    input logic send_crc, input logic [7:0] crcv, input int gap_all,
                    input int gap_lo, output logic [4:0] acks);
    logic a;
    bus_start();
    send_byte(adr, a);       acks[4] = a; tick(gap_all);
    send_byte(cmd, a);       acks[3] = a; tick(gap_all);
    send_byte(d[7:0], a);    acks[2] = a; tick(gap_all + gap_lo);
    send_byte(d[15:8], a);   acks[1] = a; tick(gap_all);
    acks[0] = 1'b0;
    if (send_crc) begin send_byte(crcv, a); acks[0] = a; end
    bus_stop();
  endtask

  task automatic rd(input logic [7:0] cmd, output logic [15:0] d, output logic [7:0] c,
                    output logic [2:0] acks);
    logic a;
    bus_start();
    send_byte(8'h16, a); acks[2] = a;
    send_byte(cmd, a);   acks[1] = a;
    bus_start();
    send_byte(8'h17, a); acks[0] = a;
    recv_byte(d[7:0], 1'b0);
    recv_byte(d[15:8], 1'b0);
    recv_byte(c, 1'b1);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++; miss++;
      $display("FAIL watchdog (all requirements): got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    logic [4:0]  a5;
    logic [2:0]  a3;
    logic [15:0] d, exp_d;
    logic [7:0]  c, ec;
    int w0, r0, s0;

    tick(10);
    // R10: reset state
    chk("R10", "outputs after reset", {28'h0, sda_pull, scl_pull, reg_we, reg_rd}, 32'h0);
    rst_n = 1'b1;
    tick(10);

    // R3: literal example, CRC 0x3B
    w0 = we_cnt;
    wr(8'h16, 8'h09, 16'hAA55, 1'b1, 8'h3B, 0, 0, a5);
    chk("R3", "acks of example write", a5, 5'b11111);
    chk("R3", "register after example write", rf[9], 16'hAA55);
    chk("R2", "single commit", we_cnt - w0, 1);

    // R5: literal read example, CRC 0x86
    wr(8'h16, 8'h09, 16'h0EC2, 1'b1, wr_crc(8'h09, 16'h0EC2), 0, 0, a5);
    r0 = rd_cnt; s0 = str_cnt;
    rd(8'h09, d, c, a3);
    chk("R5", "read acks", a3, 3'b111);
    chk("R5", "read data", d, 16'h0EC2);
    chk("R5", "read CRC example", c, 8'h86);
    chk("R6", "read strobes per read", rd_cnt - r0, 1);
    chk("R6", "stretch cycles per read", str_cnt - s0, 2);

    // R1 R2 R5: sweep over legal commands
    for (int k = 2; k < 64; k += 3) begin
      exp_d = 16'(k * 16'h0403) ^ 16'hC35A;
      w0 = we_cnt; s0 = str_cnt;
      wr(8'h16, 8'(k), exp_d, 1'b1, wr_crc(8'(k), exp_d), 0, 0, a5);
      chk("R2", "sweep write acks", a5, 5'b11111);
      chk("R2", "sweep commit count", we_cnt - w0, 1);
      chk("R6", "no stretch on write", str_cnt - s0, 0);
      chk("R2", "sweep register", rf[k], exp_d);
      rd(8'(k), d, c, a3);
      ec = ref_crc(ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h16), 8'(k)), 8'h17), exp_d[7:0]), exp_d[15:8]);
      chk("R1", "sweep read acks", a3, 3'b111);
      chk("R5", "sweep read data", d, exp_d);
      chk("R5", "sweep read CRC", c, ec);
    end

    // R4: wrong CRC acknowledged but not committed
    exp_d = rf[16]; w0 = we_cnt;
    wr(8'h16, 8'h10, 16'h1234, 1'b1, ~wr_crc(8'h10, 16'h1234), 0, 0, a5);
    chk("R4", "wrong CRC acks", a5, 5'b11111);
    chk("R4", "wrong CRC no strobe", we_cnt - w0, 0);
    chk("R4", "wrong CRC register kept", rf[16], exp_d);
    // R4: missing CRC
    wr(8'h16, 8'h10, 16'h4321, 1'b0, 8'h00, 0, 0, a5);
    chk("R4", "missing CRC no strobe", we_cnt - w0, 0);
    chk("R4", "missing CRC register kept", rf[16], exp_d);

    // R7: prohibited commands
    foreach (c[i]) ;
    for (int k = 0; k < 5; k++) begin
      logic [7:0] bc;
      bc = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h40 : (k == 3) ? 8'h7F : 8'hFF;
      w0 = we_cnt;
      wr(8'h16, bc, 16'hBEEF, 1'b1, wr_crc(bc, 16'hBEEF), 0, 0, a5);
      chk("R7", "prohibited command acks", a5, 5'b10000);
      chk("R7", "prohibited command no strobe", we_cnt - w0, 0);
    end

    // R1: foreign addresses
    w0 = we_cnt;
    wr(8'h18, 8'h05, 16'h7777, 1'b1, 8'h00, 0, 0, a5);
    chk("R1", "foreign address 0x18 acks", a5, 5'b00000);
    wr(8'h14, 8'h05, 16'h7777, 1'b1, 8'h00, 0, 0, a5);
    chk("R1", "foreign address 0x14 acks", a5, 5'b00000);
    chk("R1", "foreign address no strobe", we_cnt - w0, 0);

    // R8: stall longer than the limit
    exp_d = rf[32]; w0 = we_cnt;
    wr(8'h16, 8'h20, 16'h9A9A, 1'b1, wr_crc(8'h20, 16'h9A9A), 0, TMO + 300, a5);
    chk("R8", "acks across timeout", a5, 5'b11100);
    chk("R8", "timeout no strobe", we_cnt - w0, 0);
    chk("R8", "timeout register kept", rf[32], exp_d);
    wr(8'h16, 8'h20, 16'h9A9A, 1'b1, wr_crc(8'h20, 16'h9A9A), 0, 0, a5);
    chk("R8", "recovery write acks", a5, 5'b11111);
    chk("R8", "recovery register", rf[32], 16'h9A9A);

    // R9: many gaps, each under the limit
    w0 = we_cnt;
    wr(8'h16, 8'h21, 16'h6C6C, 1'b1, wr_crc(8'h21, 16'h6C6C), (TMO * 7) / 10, 0, a5);
    chk("R9", "gapped write acks", a5, 5'b11111);
    chk("R9", "gapped write commit", we_cnt - w0, 1);
    chk("R9", "gapped write register", rf[33], 16'h6C6C);
    chk("R10", "idle outputs at end", {30'h0, sda_pull, scl_pull}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule